// File: doc/BRIEF.md
# Look-Ahead Adder with Hex Digit Display

This unit adds two 4-bit operands and a carry-in bit. Every carry is formed in parallel from per-bit generate and propagate terms, so no carry waits on a chain of lower carries. The 5-bit result can be read as two hexadecimal digits. A single select input chooses which digit goes to one seven-segment decoder. The raw 5-bit sum is also brought out, so the arithmetic can be observed directly.

The unit is purely combinational. It has no clock and no state: every output follows its inputs. Its typical use is beside one display position. A toggle input flips that position between the low digit of the sum and the high digit. The high digit reflects only the carry-out.

Top module: `hex_cla_display`

## Requirements
- R1: `sum_o` equals `a_i + b_i + carry_i` as a 5-bit unsigned value, for all 512 operand and carry-in combinations.
- R2: Carries come from generate (`a & b`) and propagate (`a ^ b`) terms in parallel. Bit 4 of `sum_o` (the carry-out) is 1 exactly when `a_i + b_i + carry_i` exceeds 15.
- R3: With `digit_hi_i` = 0, the decoder is fed the low digit `sum_o[3:0]`.
- R4: With `digit_hi_i` = 1, the decoder is fed the high digit `{3'b000, sum_o[4]}`, so the display can only show 0 or 1.
- R5: `seg_o` is active-high, with bit 0 = top (a), bit 1 = upper right (b), bit 2 = lower right (c), bit 3 = bottom (d), bit 4 = lower left (e), bit 5 = upper left (f) and bit 6 = middle (g). Values 0 to 9 give the glyphs 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R6: Values 10 to 15 show the glyphs A, b, C, d, E and F (b and d in lower case), encoded as 0x77, 0x7C, 0x39, 0x5E, 0x79 and 0x71.
- R7: All outputs depend only on the present inputs. With all inputs at 0, `sum_o` is 0 and `seg_o` is 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| carry_i | input | 1 | Carry-in, 1 while asserted |
| digit_hi_i | input | 1 | 1 selects the high digit, 0 the low digit |
| seg_o | output | 7 | Active-high segment lines, bit 0 = a through bit 6 = g |
| sum_o | output | 5 | Raw sum, bit 4 is the carry-out |

## Verification
Carry-out formation and high-digit selection meet in the same evaluation. When the operands push the sum past 15 while `digit_hi_i` is 1, the look-ahead carry alone decides whether the display shows 0 or 1. The exhaustive sweep applies every operand and carry-in pair under both select values, so every carry-crossing vector is seen with the high digit chosen. In each such vector the segment pattern is judged against a glyph table held in the bench, indexed by the digit that the bench computes from plain integer addition.

// File: rtl/hex_cla_pkg.sv
package hex_cla_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_W = 7;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/cla_carry_gen.sv
module cla_carry_gen #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] g, p;
  logic [W:0]   cy;
  logic         term;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  // Each carry is a flat sum of products over g/p and cin; no carry feeds another.
  always_comb begin
    cy    = '0;
    term  = 1'b0;
    cy[0] = cin_i;
    for (int i = 0; i < int'(W); i++) begin
      term = cin_i;
      for (int j = 0; j <= i; j++) term = term & p[j];
      cy[i+1] = term;
      for (int k = 0; k <= i; k++) begin
        term = g[k];
        for (int j = k + 1; j <= i; j++) term = term & p[j];
        cy[i+1] = cy[i+1] | term;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < int'(W); gi++) begin : g_sum
      assign sum_o[gi] = p[gi] ^ cy[gi];
    end
  endgenerate

  assign cout_o = cy[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_sum_R1: assert ({cout_o, sum_o} == ((W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i)))
        else $error("R1 sum mismatch");
      assert_carry_R2: assert (cy[W] == (g[W-1] | (p[W-1] & cy[W-1])))
        else $error("R2 look-ahead carry inconsistent");
    end
  end
endmodule

// File: rtl/digit_sel.sv
module digit_sel #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         pick_hi_i,
  output logic [W-1:0] nib_o
);
  assign nib_o = pick_hi_i ? hi_i : lo_i;
endmodule

// File: rtl/hex_seg_dec.sv
module hex_seg_dec
  import hex_cla_pkg::*;
(
  input  nib_t nib_i,
  output seg_t seg_o
);
  // bit0=a top ... bit6=g middle, active-high
  always_comb begin
    unique case (nib_i)
      4'h0: seg_o = 7'h3F;
      4'h1: seg_o = 7'h06;
      4'h2: seg_o = 7'h5B;
      4'h3: seg_o = 7'h4F;
      4'h4: seg_o = 7'h66;
      4'h5: seg_o = 7'h6D;
      4'h6: seg_o = 7'h7D;
      4'h7: seg_o = 7'h07;
      4'h8: seg_o = 7'h7F;
      4'h9: seg_o = 7'h6F;
      4'hA: seg_o = 7'h77;
      4'hB: seg_o = 7'h7C;
      4'hC: seg_o = 7'h39;
      4'hD: seg_o = 7'h5E;
      4'hE: seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end

  always_comb begin
    if (!$isunknown(nib_i)) begin
      assert_lit_R5: assert (seg_o != '0 && seg_o[6:1] != '0)
        else $error("R5 glyph too sparse");
    end
  end
endmodule

// File: rtl/hex_cla_display.sv
module hex_cla_display
  import hex_cla_pkg::*;
#(
  parameter int unsigned OP_W = 4
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic            carry_i,
  input  logic            digit_hi_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OP_W:0]   sum_o
);
  localparam int unsigned SUM_W = OP_W + 1;

  logic [OP_W-1:0] add_s;
  logic            add_c;
  nib_t            lo_nib, hi_nib, sel_nib;

  cla_carry_gen #(.W(OP_W)) u_cla (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (carry_i),
    .sum_o  (add_s),
    .cout_o (add_c)
  );

  assign sum_o  = {add_c, add_s};
  assign lo_nib = nib_t'(sum_o);
  assign hi_nib = nib_t'(sum_o >> NIB_W);

  digit_sel #(.W(NIB_W)) u_sel (
    .lo_i      (lo_nib),
    .hi_i      (hi_nib),
    .pick_hi_i (digit_hi_i),
    .nib_o     (sel_nib)
  );

  hex_seg_dec u_dec (
    .nib_i (sel_nib),
    .seg_o (seg_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, carry_i, digit_hi_i}) && SUM_W == 5) begin
      assert_hi_R4: assert (!digit_hi_i || seg_o == 7'h3F || seg_o == 7'h06)
        else $error("R4 high digit not 0 or 1");
      assert_lo_R3: assert (digit_hi_i || (sum_o[3:0] != 4'h0) || seg_o == 7'h3F)
        else $error("R3 low digit zero not shown as 0");
    end
  end
endmodule

// File: tb/hex_cla_display_test.sv
module hex_cla_display_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a, b;
  logic       cin, dhi;
  logic [6:0] seg;
  logic [4:0] sum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] a, b;
    logic       c, d;
    logic [4:0] exp_sum;
    logic [6:0] exp_seg;
  } item_t;
  item_t q[$];

  hex_cla_display uut (
    .a_i(a), .b_i(b), .carry_i(cin), .digit_hi_i(dhi),
    .seg_o(seg), .sum_o(sum)
  );

  function automatic logic [6:0] glyph(input int v);
    case (v)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic drive(input int av, input int bv, input int cv, input int dv);
    item_t it;
    int total;
    @(posedge clk);
    a = 4'(av); b = 4'(bv); cin = 1'(cv); dhi = 1'(dv);
    total = av + bv + cv;
    it.a = a; it.b = b; it.c = cin; it.d = dhi;
    it.exp_sum = 5'(total);
    it.exp_seg = dv != 0 ? glyph(total / 16) : glyph(total % 16);
    q.push_back(it);
  endtask

  // monitor: compare away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (sum !== it.exp_sum) begin
          errors++;
          $display("FAIL R1 a=%0d b=%0d c=%0d sum=%0d exp=%0d", it.a, it.b, it.c, sum, it.exp_sum);
        end
        checks++;
        if (sum[4] !== it.exp_sum[4]) begin
          errors++;
          $display("FAIL R2 carry-out=%0b exp=%0b", sum[4], it.exp_sum[4]);
        end
        checks++;
        if (seg !== it.exp_seg) begin
          errors++;
          if (it.d)
            $display("FAIL R4 hi digit seg=%h exp=%h", seg, it.exp_seg);
          else if (it.exp_sum[3:0] > 9)
            $display("FAIL R6 letter seg=%h exp=%h", seg, it.exp_seg);
          else
            $display("FAIL R3 R5 lo digit seg=%h exp=%h", seg, it.exp_seg);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0; dhi = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (sum !== 5'd0 || seg !== 7'h3F) begin
      errors++;
      $display("FAIL R7 idle sum=%0d seg=%h exp sum=0 seg=3f", sum, seg);
    end
    // exhaustive sweep, both digits (R1 R2 R3 R4 R5 R6)
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 2; c++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            drive(x, y, c, d);
    // carry boundary toggling select back to back
    drive(15, 0, 1, 1);
    drive(15, 0, 1, 0);
    drive(15, 0, 0, 1);
    drive(8, 7, 1, 0);
    drive(15, 15, 1, 0);
    repeat (3) @(posedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule